// File: doc/BRIEF.md
# ODT Minimum High-Time Checker

This block is a passive protocol monitor for a DDR3 command interface. It samples the registered on-die termination control line on every clock, together with the write strobe and the burst mode of each write. It reports when the control line is dropped before its minimum high time has run out.

Two hold rules apply. The first rule starts when the control line is sampled high after being low. From that cycle the line must stay high for 4 cycles. The second rule starts when a write is sampled while the line is high. From that write the line must stay high for 4 cycles for a chopped burst of four, or 6 cycles for a burst of eight. Each rule keeps whichever deadline ends later. A later write can therefore extend the hold, but it can never shorten it.

When a drop comes too early, the block raises a one-cycle violation pulse and a two-bit code that names the rule, or rules, that failed.

Top module: `odt_hold_checker`

## Requirements
- R1: After reset, and until the first violation, `viol_o` is 0 and `viol_code_o` is 2'b00.
- R2: If `odt_i` is sampled high at edge t after being low at edge t-1, and is then sampled low at edge t+1, t+2 or t+3, the checker flags a violation with `viol_code_o` bit 0 set (2'b01 when no write rule fails).
- R3: If `odt_i` stays high through edge t+3 and is sampled low at edge t+4 or later, the assertion rule flags nothing.
- R4: If a write (`wr_i`=1, `bl8_i`=0) is sampled with `odt_i` high at edge w, a low sample at w+1 to w+3 sets `viol_code_o` bit 1 (2'b10 when the assertion rule holds). A low sample at w+4 or later flags nothing.
- R5: If a write with `bl8_i`=1 is sampled with `odt_i` high at edge w, a low sample at w+1 to w+5 sets bit 1. A low sample at w+6 or later flags nothing.
- R6: When several writes fall within one high period, the write rule holds until the latest of their deadlines. A short write issued after a long one does not pull the deadline in.
- R7: A write sampled while `odt_i` is low starts no hold requirement.
- R8: When both rules fail at the same low sample, `viol_code_o` is 2'b11.
- R9: A violation appears on `viol_o` during the single cycle that follows the edge at which the early low was sampled. `viol_code_o` is nonzero exactly in that cycle. A drop that stays low for several cycles gives only one pulse.
- R10: `bl8_i` has no effect when `wr_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| odt_i | input | 1 | Registered termination control line |
| wr_i | input | 1 | Write command registered this cycle |
| bl8_i | input | 1 | Burst mode of the write: 1 = eight beats, 0 = chopped four |
| viol_o | output | 1 | One-cycle early-drop pulse |
| viol_code_o | output | 2 | Failed rule: 01 assertion, 10 write, 11 both, 00 none |

## Verification
The bench drops the line exactly one cycle before and exactly at each deadline: 4 cycles after a rise, 4 after a short write and 6 after a long write. A design with an off-by-one window or with the two burst lengths swapped misses one of these drops or flags a legal one.

Two write orders are covered. In one, a short write is followed by a long one, which must extend the deadline. In the other, a long write is followed by a short one, which must not cut the deadline back. A design that reloads the window unconditionally would accept the early drop in the second case.

Further stimulus covers:
- a rise and a long write in the same cycle, which must give code 11;
- writes issued while the line is low;
- a burst-mode input toggled with no write present;
- a drop held low for several cycles, which must give one pulse, not a train.

// File: rtl/odt_chk_pkg.sv
package odt_chk_pkg;
  localparam int unsigned NUM_RULES = 2;
  localparam int unsigned RULE_ODT  = 0;
  localparam int unsigned RULE_WR   = 1;

  typedef enum logic [1:0] {
    VIOL_NONE = 2'b00,
    VIOL_ODT  = 2'b01,
    VIOL_WR   = 2'b10,
    VIOL_BOTH = 2'b11
  } viol_code_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hold_window.sv
module hold_window #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             keep_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] rem_q, rem_d, base, load;

  always_comb begin
    base  = (rem_q != '0) ? rem_q - 1'b1 : '0;
    load  = (len_i != '0) ? len_i - 1'b1 : '0;
    rem_d = base;
    if (!keep_i)                    rem_d = '0;
    else if (start_i && load > base) rem_d = load;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  assign busy_o = (rem_q != '0);

  // R6
  no_shorten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_i && rem_q > 1) |=> (rem_q >= $past(rem_q) - 1'b1));

  // R9
  clear_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_i |=> !busy_o);
endmodule

// File: rtl/odt_hold_checker.sv
module odt_hold_checker
  import odt_chk_pkg::*;
#(
  parameter int unsigned HOLD_ODT = 4,
  parameter int unsigned HOLD_BC4 = 4,
  parameter int unsigned HOLD_BL8 = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       odt_i,
  input  logic       wr_i,
  input  logic       bl8_i,
  output logic       viol_o,
  output logic [1:0] viol_code_o
);
  localparam int unsigned HOLD_MAX = max_u(HOLD_ODT, max_u(HOLD_BC4, HOLD_BL8));
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);

  logic                 odt_q;
  logic [NUM_RULES-1:0] start, busy, fail;
  logic [CNT_W-1:0]     len [NUM_RULES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odt_q <= 1'b0;
    else         odt_q <= odt_i;
  end

  assign start[RULE_ODT] = odt_i & ~odt_q;
  assign len[RULE_ODT]   = CNT_W'(HOLD_ODT);
  // write only counts while the line is high
  assign start[RULE_WR]  = wr_i & odt_i;
  assign len[RULE_WR]    = bl8_i ? CNT_W'(HOLD_BL8) : CNT_W'(HOLD_BC4);

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    hold_window #(.CNT_W(CNT_W)) u_win (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start[g]),
      .len_i  (len[g]),
      .keep_i (odt_i),
      .busy_o (busy[g])
    );
    assign fail[g] = busy[g] & ~odt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_code_o <= VIOL_NONE;
    end else begin
      viol_o      <= |fail;
      viol_code_o <= fail;
    end
  end

  // R9
  code_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_code_o != VIOL_NONE));
  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !viol_o);
  // R9
  pulse_after_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_o) |-> !$past(odt_i));
  // R2
  rise_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odt_i && !odt_q) |=> busy[RULE_ODT]);
  // R7
  low_write_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !odt_i) |=> !busy[RULE_WR]);
endmodule

// File: tb/odt_hold_checker_test.sv
module odt_hold_checker_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       odt = 1'b0, wr = 1'b0, bl8 = 1'b0;
  logic       viol;
  logic [1:0] code;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  // reference model state (absolute sample indices)
  int  k = 0;
  bit  m_odt_prev = 0;
  int  a_end = 0, w_end = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  odt_hold_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .odt_i(odt), .wr_i(wr), .bl8_i(bl8),
    .viol_o(viol), .viol_code_o(code)
  );

  task automatic step(input bit o, input bit w, input bit b, input string tag);
    logic [1:0] e;
    @(negedge clk);
    odt = o; wr = w; bl8 = b;
    k++;
    e = 2'b00;
    if (!o) begin
      e[0] = (k < a_end);
      e[1] = (k < w_end);
      a_end = 0; w_end = 0;
    end else begin
      if (!m_odt_prev) a_end = k + 4;
      if (w) w_end = (w_end > k + (b ? 6 : 4)) ? w_end : k + (b ? 6 : 4);
    end
    m_odt_prev = o;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input bit o, input int n, input string tag);
    for (int i = 0; i < n; i++) step(o, 0, 0, tag);
  endtask

  // monitor: compares outputs of the previous sample
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && exp_q.size() > 0 && !done) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (viol !== (e != 2'b00) || code !== e) begin
          n_bad++;
          $display("FAIL %s: viol=%0b code=%b expected viol=%0b code=%b",
                   t, viol, code, (e != 2'b00), e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (viol !== 1'b0 || code !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: viol=%0b code=%b expected 0 00", viol, code);
    end
    rst_n = 1'b1;
    run(0, 2, "R1");
    // R2: early drop after rise, one pulse on a long low (R9)
    run(1, 3, "R2"); run(0, 1, "R2"); run(0, 3, "R9");
    run(1, 1, "R2"); run(0, 2, "R2");
    // R3: drop exactly at and after deadline
    run(1, 4, "R3"); run(0, 2, "R3");
    run(1, 7, "R3"); run(0, 2, "R3");
    // R4: short write, early and on time
    run(1, 5, "R4"); step(1, 1, 0, "R4"); run(1, 2, "R4"); run(0, 2, "R4");
    run(1, 5, "R4"); step(1, 1, 0, "R4"); run(1, 3, "R4"); run(0, 2, "R4");
    // R5: long write, early and on time
    run(1, 5, "R5"); step(1, 1, 1, "R5"); run(1, 4, "R5"); run(0, 2, "R5");
    run(1, 5, "R5"); step(1, 1, 1, "R5"); run(1, 5, "R5"); run(0, 2, "R5");
    // R8: rise and long write together, early drop
    step(1, 1, 1, "R8"); run(1, 1, "R8"); run(0, 2, "R8");
    // R6: short then long extends
    run(1, 5, "R6"); step(1, 1, 0, "R6"); run(1, 1, "R6"); step(1, 1, 1, "R6");
    run(1, 2, "R6"); run(0, 2, "R6");
    // R6: long then short does not shorten
    run(1, 5, "R6"); step(1, 1, 1, "R6"); step(1, 1, 0, "R6");
    run(1, 3, "R6"); run(0, 2, "R6");
    // R7: writes while low start nothing
    step(0, 1, 1, "R7"); step(0, 1, 0, "R7"); run(1, 4, "R7"); run(0, 2, "R7");
    // R10: burst mode toggled with no write
    run(1, 4, "R10");
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R10");
    run(0, 2, "R10");
    run(0, 3, "R1");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule